// File: doc/BRIEF.md
# Touch Matrix Burst Scan Sequencer

This block times the acquisition bursts for a capacitive key matrix built from 8 X drive lines and 3 Y sense lines. It visits the keys one at a time. For each enabled key it drives a per-key number of X pulses. After each pulse the Y line of that key is gated for a fixed dwell window. When the burst is finished it waits a programmed spacing and moves on to the next enabled key. Once the last enabled key of a pass is done, it runs a fixed self-test slot and then begins a new pass from key 0.

Keys that are switched off take no time in the scan at all. The sequencer also drives the per-key status that a disabled key must present to the rest of the sensing path. The configuration array (enable fields and burst lengths) and the spacing value are read only at the start of each pass. A configuration that enables more keys than the device limit is refused, and the previous one stays in force. Downstream conversion logic learns which key has just completed its burst from an end-of-burst strobe that carries the key index.

Top module: `touch_scan_seq`

## Requirements
- R1: Key k sits at X = k mod 8 and Y = k div 8. While key k is sampled, `x_drive` has only bit X set and `y_gate` has only bit Y set. Within a pass, keys are visited in ascending index order starting from the lowest enabled key. Every pass starts again from key 0.
- R2: A key whose 4-bit enable field in `cfg_ndil` (bits 4k+3..4k) is zero is disabled. A disabled key receives no X pulse and no strobe.
- R3: Key k receives exactly `cfg_bl[8k+7:8k]` X pulses, and a value of 0 counts as 1. `burst_done` is high for one cycle, in the last dwell cycle of the final pulse, with `burst_key` equal to k. The next key's first pulse comes after that strobe.
- R4: Each X pulse lasts one cycle. It is followed directly by DWELL_CYC cycles in which `y_gate` is active and `x_drive` is zero.
- R5: After each strobe, exactly `cfg_spacing` cycles pass with no drive and no self-test before the next pulse or the self-test slot begins.
- R6: After the last enabled key's spacing, `selftest_active` is high for exactly ST_CYC cycles. A single idle pass-start cycle follows, and then the next pass begins.
- R7: When no key is enabled, each pass consists only of the start cycle and the self-test slot, and `x_drive` stays zero.
- R8: The enable fields, burst lengths and spacing are sampled in the pass-start cycle only. A change made during a pass takes effect on the following pass.
- R9: A configuration that enables more than MAX_EN (16) keys is rejected when it is sampled. The previous enables and burst lengths stay in force, and `cfg_reject` is high for one cycle in the cycle after the pass-start cycle.
- R10: After reset, keys 0 to 15 (the Y0 and Y1 lines) are enabled with a burst length of DEF_BL (2) until a valid configuration is loaded.
- R11: `key_off[k]` is 1 exactly when key k is disabled in the configuration in force. This single bit tells the downstream path to hold signal and reference at zero, to keep the failed-calibration flag set and to block detection.
- R12: `cal_flag[k]` equals `key_off[k]` during the first pass that starts after reset, and during the first pass that starts after a `cal_req` pulse. In every other pass it is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cfg_ndil | input | 96 | Per-key 4-bit enable field; zero disables the key |
| cfg_bl | input | 192 | Per-key 8-bit burst length in pulses |
| cfg_spacing | input | 8 | Idle cycles after each burst |
| cal_req | input | 1 | One-cycle calibrate request |
| x_drive | output | 8 | One-hot X pulse drive |
| y_gate | output | 3 | One-hot Y capture gate during the dwell |
| burst_done | output | 1 | End-of-burst strobe |
| burst_key | output | 5 | Index of the key whose burst is ending |
| selftest_active | output | 1 | End-of-pass self-test slot |
| cfg_reject | output | 1 | Pulse when a sampled configuration breaks the key limit |
| key_off | output | 24 | Disabled-key status mask |
| cal_flag | output | 24 | Calibrating flag of disabled keys |

## Verification
The assertions assume that the configuration inputs are stable around each clock edge and that `cal_req` is a single-cycle pulse. The bench meets both conditions by changing inputs only shortly after a rising edge. The assertions do not assume that the configuration stays fixed within a pass, and the stimulus deliberately rewrites it mid-pass and during the self-test slot. Burst lengths of 0 and enable counts just above the limit are produced both directly and by the seeded random mix, so the rejection path and the zero-as-one rule are exercised without breaking any assumption.

// File: rtl/touch_scan_pkg.sv
package touch_scan_pkg;
  typedef enum logic [2:0] {
    S_START = 3'd0,
    S_PULSE = 3'd1,
    S_DWELL = 3'd2,
    S_SPACE = 3'd3,
    S_TEST  = 3'd4
  } scan_state_t;
endpackage

// File: rtl/tms_cfg_latch.sv
module tms_cfg_latch #(
  parameter int NK      = 24,
  parameter int NDW     = 4,
  parameter int BLW     = 8,
  parameter int MAX_EN  = 16,
  parameter int DEF_NEN = 16,
  parameter int DEF_BL  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [NK*NDW-1:0] cfg_ndil,
  input  logic [NK*BLW-1:0] cfg_bl,
  output logic [NK-1:0]     eff_en,
  output logic [NK-1:0]     act_en,
  output logic [NK*BLW-1:0] act_bl,
  output logic              reject
);
  localparam int CW = $clog2(NK + 1);

  logic [NK-1:0]     new_en;
  logic [NK-1:0]     def_en;
  logic [NK*BLW-1:0] def_bl;
  logic [CW-1:0]     new_cnt;
  logic              over;
  logic [NK-1:0]     act_en_d;
  logic [NK*BLW-1:0] act_bl_d;
  logic              reject_d;

  for (genvar k = 0; k < NK; k++) begin : g_key
    assign new_en[k] = |cfg_ndil[k*NDW +: NDW];
    assign def_en[k] = (k < DEF_NEN);
    assign def_bl[k*BLW +: BLW] = BLW'(DEF_BL);
  end

  always_comb begin
    new_cnt = '0;
    for (int k = 0; k < NK; k++) new_cnt = new_cnt + CW'(new_en[k]);
  end

  assign over   = (new_cnt > CW'(MAX_EN));
  assign eff_en = (load && !over) ? new_en : act_en;

  always_comb begin
    act_en_d = act_en;
    act_bl_d = act_bl;
    reject_d = 1'b0;
    if (load) begin
      if (over) begin
        reject_d = 1'b1;
      end else begin
        act_en_d = new_en;
        act_bl_d = cfg_bl;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_en <= def_en;
      act_bl <= def_bl;
      reject <= 1'b0;
    end else begin
      act_en <= act_en_d;
      act_bl <= act_bl_d;
      reject <= reject_d;
    end
  end

  a_r9_limit: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(act_en) <= MAX_EN);
  a_r9_hold_on_reject: assert property (@(posedge clk) disable iff (!rst_n)
    reject |-> ($stable(act_en) && $stable(act_bl)));
endmodule

// File: rtl/tms_key_pick.sv
module tms_key_pick #(
  parameter int NK = 24,
  parameter int KW = 5
) (
  input  logic [NK-1:0] mask,
  input  logic [KW-1:0] cur,
  input  logic          from_start,
  output logic          found,
  output logic [KW-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int k = NK - 1; k >= 0; k--) begin
      if (mask[k] && (from_start || (KW'(k) > cur))) begin
        found = 1'b1;
        idx   = KW'(k);
      end
    end
  end
endmodule

// File: rtl/tms_burst_engine.sv
module tms_burst_engine
  import touch_scan_pkg::*;
#(
  parameter int NX        = 8,
  parameter int NY        = 3,
  parameter int KW        = 5,
  parameter int BLW       = 8,
  parameter int SPW       = 8,
  parameter int DWELL_CYC = 3,
  parameter int ST_CYC    = 40
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [SPW-1:0] cfg_spacing,
  input  logic [BLW-1:0] cur_bl,
  input  logic           pick_found,
  input  logic [KW-1:0]  pick_idx,
  output logic           load,
  output logic [KW-1:0]  cur_key,
  output logic [NX-1:0]  x_drive,
  output logic [NY-1:0]  y_gate,
  output logic           burst_done,
  output logic           selftest_active
);
  localparam int DCW = $clog2(DWELL_CYC + 1);
  localparam int TCW = $clog2(ST_CYC + 1);

  scan_state_t    state, state_d;
  logic [KW-1:0]  cur_d;
  logic [BLW-1:0] pcnt, pcnt_d;
  logic [DCW-1:0] dcnt, dcnt_d;
  logic [SPW-1:0] scnt, scnt_d;
  logic [SPW-1:0] sp_q, sp_d;
  logic [TCW-1:0] tcnt, tcnt_d;
  logic           last_pulse, dwell_end, go_next;
  logic [KW-1:0]  xi, yi;

  assign last_pulse = ({1'b0, pcnt} + 1'b1) >= {1'b0, cur_bl};
  assign dwell_end  = (dcnt == DCW'(DWELL_CYC - 1));
  assign load       = (state == S_START);
  assign burst_done = (state == S_DWELL) && dwell_end && last_pulse;
  assign selftest_active = (state == S_TEST);

  assign xi = cur_key % KW'(NX);
  assign yi = cur_key / KW'(NX);
  assign x_drive = (state == S_PULSE) ? (NX'(1) << xi) : '0;
  assign y_gate  = (state == S_DWELL) ? (NY'(1) << yi) : '0;

  always_comb begin
    state_d = state;
    cur_d   = cur_key;
    pcnt_d  = pcnt;
    dcnt_d  = dcnt;
    scnt_d  = scnt;
    sp_d    = sp_q;
    tcnt_d  = tcnt;
    go_next = 1'b0;
    case (state)
      S_START: begin
        sp_d    = cfg_spacing;
        go_next = 1'b1;
      end
      S_PULSE: begin
        state_d = S_DWELL;
        dcnt_d  = '0;
      end
      S_DWELL: begin
        if (!dwell_end) begin
          dcnt_d = dcnt + 1'b1;
        end else if (!last_pulse) begin
          pcnt_d  = pcnt + 1'b1;
          state_d = S_PULSE;
        end else if (sp_q != '0) begin
          state_d = S_SPACE;
          scnt_d  = '0;
        end else begin
          go_next = 1'b1;
        end
      end
      S_SPACE: begin
        if (scnt == sp_q - SPW'(1)) go_next = 1'b1;
        else                        scnt_d  = scnt + 1'b1;
      end
      S_TEST: begin
        if (tcnt == TCW'(ST_CYC - 1)) state_d = S_START;
        else                          tcnt_d  = tcnt + 1'b1;
      end
      default: state_d = S_START;
    endcase
    if (go_next) begin
      if (pick_found) begin
        state_d = S_PULSE;
        cur_d   = pick_idx;
        pcnt_d  = '0;
      end else begin
        state_d = S_TEST;
        tcnt_d  = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_START;
      cur_key <= '0;
      pcnt    <= '0;
      dcnt    <= '0;
      scnt    <= '0;
      sp_q    <= '0;
      tcnt    <= '0;
    end else begin
      state   <= state_d;
      cur_key <= cur_d;
      pcnt    <= pcnt_d;
      dcnt    <= dcnt_d;
      scnt    <= scnt_d;
      sp_q    <= sp_d;
      tcnt    <= tcnt_d;
    end
  end

  a_r1_xdrive_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(x_drive) && $onehot0(y_gate));
  a_r4_pulse_then_dwell: assert property (@(posedge clk) disable iff (!rst_n)
    (x_drive != '0) |=> ((y_gate != '0) && (x_drive == '0)));
  a_r3_done_ends_dwell: assert property (@(posedge clk) disable iff (!rst_n)
    burst_done |=> (y_gate == '0));
  a_r6_test_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(selftest_active) |-> (x_drive == '0 && !burst_done));
endmodule

// File: rtl/tms_key_status.sv
module tms_key_status #(
  parameter int NK = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          cal_req,
  input  logic [NK-1:0] act_en,
  output logic [NK-1:0] key_off,
  output logic [NK-1:0] cal_flag
);
  logic cal_pend, cal_pend_d;
  logic cal_pass, cal_pass_d;

  always_comb begin
    cal_pend_d = cal_pend | cal_req;
    cal_pass_d = cal_pass;
    if (load) begin
      cal_pass_d = cal_pend;
      cal_pend_d = cal_req;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cal_pend <= 1'b1;
      cal_pass <= 1'b0;
    end else begin
      cal_pend <= cal_pend_d;
      cal_pass <= cal_pass_d;
    end
  end

  assign key_off  = ~act_en;
  assign cal_flag = cal_pass ? key_off : '0;

  a_r12_flag_steady: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(load) |-> $stable(cal_pass));
endmodule

// File: rtl/touch_scan_seq.sv
module touch_scan_seq #(
  parameter int NX        = 8,
  parameter int NY        = 3,
  parameter int NDW       = 4,
  parameter int BLW       = 8,
  parameter int SPW       = 8,
  parameter int DWELL_CYC = 3,
  parameter int ST_CYC    = 40,
  parameter int MAX_EN    = 16,
  parameter int DEF_NEN   = 16,
  parameter int DEF_BL    = 2,
  localparam int NK       = NX * NY,
  localparam int KW       = $clog2(NK)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NK*NDW-1:0] cfg_ndil,
  input  logic [NK*BLW-1:0] cfg_bl,
  input  logic [SPW-1:0]    cfg_spacing,
  input  logic              cal_req,
  output logic [NX-1:0]     x_drive,
  output logic [NY-1:0]     y_gate,
  output logic              burst_done,
  output logic [KW-1:0]     burst_key,
  output logic              selftest_active,
  output logic              cfg_reject,
  output logic [NK-1:0]     key_off,
  output logic [NK-1:0]     cal_flag
);
  logic [1:0]        rs;
  logic              srst_n;
  logic              load;
  logic [NK-1:0]     eff_en, act_en;
  logic [NK*BLW-1:0] act_bl;
  logic [KW-1:0]     cur_key;
  logic              pick_found;
  logic [KW-1:0]     pick_idx;
  logic [BLW-1:0]    cur_bl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs <= 2'b00;
    else        rs <= {rs[0], 1'b1};
  end
  assign srst_n = rs[1];

  tms_cfg_latch #(
    .NK(NK), .NDW(NDW), .BLW(BLW), .MAX_EN(MAX_EN),
    .DEF_NEN(DEF_NEN), .DEF_BL(DEF_BL)
  ) u_cfg (
    .clk(clk), .rst_n(srst_n), .load(load), .cfg_ndil(cfg_ndil),
    .cfg_bl(cfg_bl), .eff_en(eff_en), .act_en(act_en),
    .act_bl(act_bl), .reject(cfg_reject)
  );

  tms_key_pick #(.NK(NK), .KW(KW)) u_pick (
    .mask(eff_en), .cur(cur_key), .from_start(load),
    .found(pick_found), .idx(pick_idx)
  );

  assign cur_bl = act_bl[cur_key*BLW +: BLW];

  tms_burst_engine #(
    .NX(NX), .NY(NY), .KW(KW), .BLW(BLW), .SPW(SPW),
    .DWELL_CYC(DWELL_CYC), .ST_CYC(ST_CYC)
  ) u_eng (
    .clk(clk), .rst_n(srst_n), .cfg_spacing(cfg_spacing),
    .cur_bl(cur_bl), .pick_found(pick_found), .pick_idx(pick_idx),
    .load(load), .cur_key(cur_key), .x_drive(x_drive), .y_gate(y_gate),
    .burst_done(burst_done), .selftest_active(selftest_active)
  );

  assign burst_key = cur_key;

  tms_key_status #(.NK(NK)) u_stat (
    .clk(clk), .rst_n(srst_n), .load(load), .cal_req(cal_req),
    .act_en(act_en), .key_off(key_off), .cal_flag(cal_flag)
  );
endmodule

// File: tb/tb_touch_scan_seq.sv
module tb_touch_scan_seq;
  localparam int CLK_PERIOD = 10;
  localparam int NX = 8, NY = 3, NK = 24, NDW = 4, BLW = 8, SPW = 8;
  localparam int DWELL = 3, STC = 40, MAXEN = 16, DEFN = 16, DEFBL = 2;

  logic clk = 1'b0;
  logic rst_n;
  logic [NK*NDW-1:0] cfg_ndil;
  logic [NK*BLW-1:0] cfg_bl;
  logic [SPW-1:0]    cfg_spacing;
  logic              cal_req;
  logic [NX-1:0] x_drive;
  logic [NY-1:0] y_gate;
  logic          burst_done;
  logic [4:0]    burst_key;
  logic          selftest_active, cfg_reject;
  logic [NK-1:0] key_off, cal_flag;

  touch_scan_seq dut (
    .clk(clk), .rst_n(rst_n), .cfg_ndil(cfg_ndil), .cfg_bl(cfg_bl),
    .cfg_spacing(cfg_spacing), .cal_req(cal_req), .x_drive(x_drive),
    .y_gate(y_gate), .burst_done(burst_done), .burst_key(burst_key),
    .selftest_active(selftest_active), .cfg_reject(cfg_reject),
    .key_off(key_off), .cal_flag(cal_flag)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int nchk = 0, nfail = 0, cyc = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int next_en(input logic [NK-1:0] m, input int from);
    for (int k = from + 1; k < NK; k++) if (m[k]) return k;
    return NK;
  endfunction

  function automatic logic [NK-1:0] mask_of(input logic [NK*NDW-1:0] nd);
    logic [NK-1:0] m;
    for (int k = 0; k < NK; k++) m[k] = |nd[k*NDW +: NDW];
    return m;
  endfunction

  // reference model state
  logic [NK-1:0] act_m;
  int  bl_m [NK];
  int  sp_m, ptr, pc, dw, sp_cnt, st_len, arm;
  bit  mon_on, prev_st, in_space, post_start, exp_rej, cal_pass_m, pend_m, x_seen;

  always @(negedge clk) begin
    if (mon_on) begin
      bit start_now;
      start_now = 0;
      if (arm > 0) begin
        arm--;
        if (arm == 0) start_now = 1;
      end
      if (prev_st && !selftest_active) begin
        chk(st_len == STC, "R6 selftest length", st_len, STC);
        start_now = 1;
      end
      if (start_now) begin
        logic [NK-1:0] nm;
        nm = mask_of(cfg_ndil);
        exp_rej = ($countones(nm) > MAXEN);
        if (!exp_rej) begin
          act_m = nm;
          for (int k = 0; k < NK; k++) bl_m[k] = int'(cfg_bl[k*BLW +: BLW]);
        end
        sp_m = int'(cfg_spacing);
        cal_pass_m = pend_m;
        pend_m = cal_req;
        ptr = next_en(act_m, -1);
        pc = 0; dw = 0; in_space = 0; x_seen = 0; post_start = 1;
      end else begin
        if (cal_req) pend_m = 1;
        if (post_start) begin
          chk(cfg_reject == exp_rej, "R9 reject pulse", cfg_reject, exp_rej);
          chk(key_off == ~act_m, "R11 key_off mask", key_off, ~act_m);
          chk(cal_flag == (cal_pass_m ? ~act_m : '0), "R12 cal_flag", cal_flag,
              cal_pass_m ? ~act_m : '0);
          post_start = 0;
        end
        if (x_drive != '0) begin
          x_seen = 1;
          if (in_space) begin
            chk(sp_cnt == sp_m, "R5 spacing before pulse", sp_cnt, sp_m);
            in_space = 0;
          end
          chk(ptr < NK, "R2 R7 pulse only for enabled key", ptr, NK - 1);
          chk(x_drive == NX'(1 << (ptr % NX)), "R1 x line", x_drive, 1 << (ptr % NX));
          if (pc > 0) chk(dw == DWELL, "R4 dwell length", dw, DWELL);
          pc++; dw = 0;
        end
        if (y_gate != '0) begin
          chk(y_gate == NY'(1 << (ptr / NX)), "R1 y line", y_gate, 1 << (ptr / NX));
          dw++;
        end
        if (burst_done) begin
          int eb;
          eb = (bl_m[ptr % NK] == 0) ? 1 : bl_m[ptr % NK];
          chk(burst_key == 5'(ptr), "R3 burst_key", burst_key, ptr);
          chk(pc == eb, "R3 pulse count", pc, eb);
          chk(dw == DWELL, "R4 last dwell", dw, DWELL);
          ptr = next_en(act_m, ptr);
          pc = 0; dw = 0; in_space = 1; sp_cnt = 0;
        end else if (in_space && x_drive == '0 && y_gate == '0 && !selftest_active) begin
          sp_cnt++;
        end
        if (selftest_active && !prev_st) begin
          if (in_space) begin
            chk(sp_cnt == sp_m, "R5 spacing before selftest", sp_cnt, sp_m);
            in_space = 0;
          end
          chk(ptr == NK, "R6 all enabled keys visited", ptr, NK);
          if (act_m == '0) chk(!x_seen, "R7 no drive when empty", x_seen, 0);
          st_len = 0;
        end
      end
      if (selftest_active) st_len++;
      prev_st = selftest_active;
    end
  end

  task automatic tick();
    @(posedge clk); #2;
  endtask

  task automatic set_cfg(input logic [NK-1:0] en, input int blmax, input int sp);
    for (int k = 0; k < NK; k++) begin
      cfg_ndil[k*NDW +: NDW] = en[k] ? NDW'(1 + $urandom % 15) : '0;
      cfg_bl[k*BLW +: BLW]   = BLW'($urandom % (blmax + 1));
    end
    cfg_spacing = SPW'(sp);
  endtask

  task automatic wait_passes(input int n);
    repeat (n) @(negedge selftest_active);
    tick();
  endtask

  task automatic pulse_cal();
    cal_req = 1'b1; tick(); cal_req = 1'b0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      finished = 1;
      chk(0, "watchdog", cyc, 150000);
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1357));
    rst_n = 1'b0; cal_req = 1'b0; mon_on = 0; arm = 0; prev_st = 0;
    act_m = NK'((1 << DEFN) - 1);
    for (int k = 0; k < NK; k++) bl_m[k] = DEFBL;
    pend_m = 1; cal_pass_m = 0; in_space = 0; post_start = 0; st_len = 0;
    ptr = NK; pc = 0; dw = 0; sp_cnt = 0; sp_m = 0; x_seen = 0; exp_rej = 0;
    set_cfg(24'h03FFFF, 4, 2);   // 18 keys: first load rejected (R9, R10)
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(x_drive == '0 && y_gate == '0, "R10 reset drive idle", {x_drive, y_gate}, 0);
    chk(!burst_done && !selftest_active && !cfg_reject, "R10 reset strobes", burst_done, 0);
    chk(key_off == 24'hFF0000, "R10 reset default enables", key_off, 24'hFF0000);
    chk(cal_flag == '0, "R12 reset cal_flag", cal_flag, 0);
    @(posedge clk); #2;
    rst_n = 1'b1; mon_on = 1; arm = 3;
    wait_passes(2);
    set_cfg(24'h800000, 5, 0);  wait_passes(2);   // only key 23 (R1)
    set_cfg(24'h000000, 5, 3);  wait_passes(2);   // none enabled (R7)
    set_cfg(24'h80FF01 | 24'h00007E, 6, 4);       // exactly 16 with key 0 and 23
    cfg_bl[0 +: BLW] = '0;                        // zero length counts as one (R3)
    pulse_cal(); wait_passes(2);
    set_cfg(24'h01FFFF, 3, 1);  wait_passes(2);   // 17 enabled: rejected (R9)
    @(negedge selftest_active); repeat (5) tick();
    set_cfg(24'h0F0F0F, 4, 2);  wait_passes(2);   // mid-pass write (R8)
    for (int i = 0; i < 20; i++) begin
      logic [NK-1:0] m;
      for (int k = 0; k < NK; k++) m[k] = ($urandom % 3) != 0;
      set_cfg(m, 6, $urandom % 6);
      if ($urandom % 4 == 0) pulse_cal();
      repeat (20 + $urandom % 600) tick();
    end
    wait_passes(2);
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end
endmodule